// File: doc/BRIEF.md
# Flash Write Qualification and Protection Gate

This block sits at the bus edge of a boot-sector flash memory model and decides, on every sample clock, whether the host is performing a read, a write or nothing. It watches the active-low select, write and read-drive controls. A write must be held valid for a minimum number of samples. When the write control then returns high, the block turns the cycle into exactly one strobe that carries the address, data and sector index taken at that moment. Command decoding, the program and erase engines and the array itself sit downstream of this strobe.

Several guards act on the strobe. The supply-low flag and the power-on reset hold the block in a write lockout. After release, the write control must be seen high before any write counts. Each of the nineteen sectors of a top-boot map has a protect bit, and a write that lands on a protected sector becomes a one-cycle reject pulse instead of a strobe. A high-voltage unlock flag overrides every protect bit while it is held. The protect vector itself is never changed, so protection applies again as soon as the flag drops.

Top module: `flash_wr_gate`

## Requirements
- R1: `is_write` is 1 exactly when `sel_n`=0, `wr_n`=0 and `rd_n`=1. Any one of `rd_n`=0, `sel_n`=1 or `wr_n`=1 blocks the write.
- R2: When `sel_n`, `wr_n` and `rd_n` are all 0, `is_read`=1 and `is_write`=0, and the cycle never produces `stb` or `reject`.
- R3: A write produces `stb` or `reject` only if `is_write` held for at least FILT_N consecutive samples just before the sample where `wr_n` is seen high. A shorter low pulse yields neither.
- R4: `stb` is a one-cycle pulse. It is visible in the cycle after the sample where `wr_n` is seen high. `stb_addr`, `stb_data` and `stb_sector` hold the address, data and sector sampled at that edge.
- R5: The `sector` output decodes word address bits 18..12 with the leftmost bit as bit 18: 111111x gives 18, 1111101 gives 17, 1111100 gives 16, 11110xx gives 15, and any other value gives the value of bits 18..15 (0 to 14).
- R6: If `prot[sector]`=1 and `hv_unlock`=0 at the qualifying edge, `stb` stays 0 and `reject` pulses for one cycle instead.
- R7: While `hv_unlock`=1, writes to protected sectors produce `stb`. Once `hv_unlock` returns to 0, the same writes produce `reject` again.
- R8: While `supply_low`=1, no write produces `stb` or `reject`, and `locked` reads 1 from the next cycle on.
- R9: The lockout clears at the first clock edge at which `rst_n`=1 and `supply_low`=0. `wr_n` must then be sampled high while unlocked before a write counts, so a write-low period that began during lockout is discarded.
- R10: While `rst_n`=0, `locked`=1 and `stb`=`reject`=0.
- R11: `stb` and `reject` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sample clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| sel_n | input | 1 | chip select, active low |
| wr_n | input | 1 | write control, active low |
| rd_n | input | 1 | read output drive, active low |
| addr | input | ADDR_W | word address |
| wdata | input | DATA_W | write data |
| prot | input | 19 | per-sector protect bits, bit i for sector i |
| supply_low | input | 1 | supply below the write threshold |
| hv_unlock | input | 1 | high voltage on reset: overrides protection |
| is_read | output | 1 | current cycle is a read |
| is_write | output | 1 | current cycle is a qualified write level |
| sector | output | SECT_W | sector index of the live address |
| stb | output | 1 | accepted write strobe |
| stb_addr | output | ADDR_W | address latched with the strobe |
| stb_data | output | DATA_W | data latched with the strobe |
| stb_sector | output | SECT_W | sector latched with the strobe |
| reject | output | 1 | write dropped by protection |
| locked | output | 1 | write lockout active |

## Verification
The hardest case to reach is a valid write-low period that begins while the block is still locked and ends after the lockout has cleared. The levels are correct and the pulse is long enough, yet no strobe may result. The bench drives valid write levels throughout reset, releases reset with the write control still low, and raises it several samples later. The same idea covers the supply-low path: the bench leaves one idle sample after the flag drops and then confirms that writes work again. Random cycles mix pulse widths on both sides of the filter limit with random protect vectors and random override states, and half of the addresses fall in the small top sectors.

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int FILT_N = 3,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [18:0]       prot,
  input  logic              supply_low,
  input  logic              hv_unlock,
  output logic              is_read,
  output logic              is_write,
  output logic [SECT_W-1:0] sector,
  output logic              stb,
  output logic [ADDR_W-1:0] stb_addr,
  output logic [DATA_W-1:0] stb_data,
  output logic [SECT_W-1:0] stb_sector,
  output logic              reject,
  output logic              locked
);
  localparam int CNT_W = $clog2(FILT_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_N);

  function automatic logic [SECT_W-1:0] decode(input logic [6:0] t);
    if (t[6:1] == 6'b111111)     return SECT_W'(18);
    else if (t == 7'b1111101)    return SECT_W'(17);
    else if (t == 7'b1111100)    return SECT_W'(16);
    else if (t[6:3] == 4'b1111)  return SECT_W'(15);
    else                         return SECT_W'(t[6:3]);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             seen_hi;
  logic             we_rise;
  logic             guarded;

  assign is_read  = !sel_n && !rd_n;
  assign is_write = !sel_n && !wr_n && rd_n;
  assign sector   = decode(addr[ADDR_W-1 -: 7]);
  assign guarded  = prot[sector] && !hv_unlock;
  assign we_rise  = wr_n && (cnt == CNT_MAX) && !supply_low && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b1;
      seen_hi    <= 1'b0;
      cnt        <= '0;
      stb        <= 1'b0;
      reject     <= 1'b0;
      stb_addr   <= '0;
      stb_data   <= '0;
      stb_sector <= '0;
    end else begin
      locked  <= supply_low;
      seen_hi <= !locked && !supply_low && (seen_hi || wr_n);
      if (seen_hi && is_write && !supply_low)
        cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      else
        cnt <= '0;
      stb    <= we_rise && !guarded;
      reject <= we_rise && guarded;
      if (we_rise) begin
        stb_addr   <= addr;
        stb_data   <= wdata;
        stb_sector <= sector;
      end
    end
  end
endmodule

// File: rtl/flash_wr_gate_chk.sv
module flash_wr_gate_chk #(
  parameter int FILT_N = 3,
  parameter int SECT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic [18:0]       prot,
  input logic              supply_low,
  input logic              hv_unlock,
  input logic              is_read,
  input logic              is_write,
  input logic              stb,
  input logic              reject,
  input logic [SECT_W-1:0] stb_sector,
  input logic              locked
);
  logic [18:0] prot_q;
  logic        hv_q;
  logic [7:0]  run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      hv_q   <= 1'b0;
      run    <= '0;
    end else begin
      prot_q <= prot;
      hv_q   <= hv_unlock;
      if (!sel_n && !wr_n && rd_n) run <= (run == 8'hFF) ? run : run + 8'd1;
      else                         run <= '0;
    end
  end

  AST_ALL_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n) (!sel_n && !wr_n && !rd_n) |-> (is_read && !is_write)); // R2
  AST_WRITE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n) is_write |-> (!sel_n && !wr_n && rd_n)); // R1
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (stb || reject) |-> ($past(run) >= 8'(FILT_N))); // R3
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) stb |=> !stb); // R4
  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) stb |-> (hv_q || !prot_q[stb_sector])); // R6
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n) reject |-> !hv_q); // R7
  AST_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n) supply_low |=> (!stb && !reject && locked)); // R8
  AST_LOCK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) locked |=> (!stb && !reject)); // R9
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(stb && reject)); // R11
endmodule

bind flash_wr_gate flash_wr_gate_chk u_chk (.*);

// File: tb/flash_wr_gate_tb.sv
module flash_wr_gate_tb;
  localparam int CLK_P = 10;
  localparam int N     = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel_n = 1, wr_n = 1, rd_n = 1;
  logic [18:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [18:0] prot = '0;
  logic        supply_low = 0, hv_unlock = 0;
  logic        is_read, is_write, stb, reject, locked;
  logic [4:0]  sector, stb_sector;
  logic [18:0] stb_addr;
  logic [15:0] stb_data;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_wr_gate #(.ADDR_W(19), .DATA_W(16), .FILT_N(N), .SECT_W(5)) u_dut (.*);

  function automatic int exp_sect(input logic [18:0] a);
    if (a >= 19'h7E000)      return 18;
    else if (a >= 19'h7D000) return 17;
    else if (a >= 19'h7C000) return 16;
    else if (a >= 19'h78000) return 15;
    else                     return int'(a >> 15);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: valid write, 1: all low (read), 2: select high
  task automatic wcyc(input logic [18:0] a, input logic [15:0] d, input int len,
                      input int mode, input bit enabled);
    bit go, prt;
    int s;
    s   = exp_sect(a);
    prt = prot[s] && !hv_unlock;
    go  = (mode == 0) && (len >= N) && enabled && !supply_low;
    @(negedge clk);
    addr = a; wdata = d; wr_n = 0;
    sel_n = (mode == 2);
    rd_n  = (mode == 1) ? 1'b0 : 1'b1;
    #1;
    chk("R1 is_write", is_write, mode == 0);
    chk("R2 is_read", is_read, mode == 1);
    chk("R5 sector", sector, s);
    repeat (len) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    chk("R3/R6 stb", stb, go && !prt);
    chk("R6 reject", reject, go && prt);
    if (go && !prt) begin
      chk("R4 stb_addr", stb_addr, a);
      chk("R4 stb_data", stb_data, d);
      chk("R4 stb_sector", stb_sector, s);
    end
    sel_n = 1; rd_n = 1;
    @(negedge clk);
    chk("R4 single pulse", stb, 0);
    chk("R11 no reject after", reject, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10 and R9: valid write levels held through reset
    sel_n = 0; rd_n = 1; wr_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 locked", locked, 1);
    chk("R10 stb", stb, 0);
    chk("R10 reject", reject, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 lock cleared", locked, 0);
    repeat (4) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    chk("R9 write from lockout dropped", stb, 0);
    sel_n = 1;
    @(negedge clk);

    // R3 filter boundary
    wcyc(19'h00123, 16'hA5A5, N - 1, 0, 1);
    wcyc(19'h00123, 16'h5A5A, N, 0, 1);
    wcyc(19'h10000, 16'h1111, 1, 0, 1);

    // R5 sector corners
    wcyc(19'h7FFFF, 16'h0001, N, 0, 1);
    wcyc(19'h7E000, 16'h0002, N, 0, 1);
    wcyc(19'h7DFFF, 16'h0003, N, 0, 1);
    wcyc(19'h7D000, 16'h0004, N, 0, 1);
    wcyc(19'h7CFFF, 16'h0005, N, 0, 1);
    wcyc(19'h7C000, 16'h0006, N, 0, 1);
    wcyc(19'h7BFFF, 16'h0007, N, 0, 1);
    wcyc(19'h78000, 16'h0008, N, 0, 1);
    wcyc(19'h77FFF, 16'h0009, N, 0, 1);
    wcyc(19'h08000, 16'h000A, N, 0, 1);

    // R1/R2 inhibit levels
    wcyc(19'h04000, 16'hBEEF, N + 2, 1, 1);
    wcyc(19'h04000, 16'hBEEF, N + 2, 2, 1);

    // R6 and R7 protection with override
    prot = '1;
    wcyc(19'h7E100, 16'hC0DE, N, 0, 1);
    hv_unlock = 1;
    wcyc(19'h7E100, 16'hC0DE, N, 0, 1);
    wcyc(19'h30000, 16'hC0DF, N, 0, 1);
    @(negedge clk);
    hv_unlock = 0;
    wcyc(19'h7E100, 16'hC0DE, N, 0, 1);
    prot = 19'h40000;
    wcyc(19'h7C800, 16'h7777, N, 0, 1);
    prot = '0;

    // R8 low supply
    @(negedge clk);
    supply_low = 1;
    @(negedge clk);
    chk("R8 locked", locked, 1);
    wcyc(19'h00200, 16'h2222, N + 1, 0, 0);
    supply_low = 0;
    @(negedge clk);
    chk("R8 lock released", locked, 0);
    @(negedge clk);
    wcyc(19'h00200, 16'h3333, N, 0, 1);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      int len, mode;
      a = 19'($urandom);
      if ($urandom % 2) a[18:15] = 4'hF;
      prot = 19'($urandom);
      hv_unlock = ($urandom % 4) == 0;
      len  = 1 + ($urandom % 5);
      mode = $urandom % 4;
      if (mode == 3) mode = 0;
      wcyc(a, 16'($urandom), len, mode, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule